// File: doc/BRIEF.md
# Reset Sequencer with Source Discrimination

This block merges four reset causes into one active-low internal reset and tells software which start-up vector to take. The causes are a cold-start power-on pulse, an external device pulling the board reset line, a watchdog timeout request and a clock-monitor failure request. The board reset line is an open-drain wire. The block models it as a drive-low enable going out and a sampled level coming back.

Any reset condition seen while the block is idle starts the same sequence. The block pulls the line low for a fixed number of clock cycles, lets it go, and looks at it again a fixed number of cycles later. If the line is still low, some outside agent is holding it, and the reset counts as external. If the line has returned high, the reset came from inside, and the latched internal request selects the vector. When both internal causes are latched, the clock-monitor cause wins.

The internal reset asserts without waiting for a clock edge. It is released through a two-flop synchronizer once every cause has gone away. The power-on input clears the whole block and is not used for brown-out.

Top module: `rst_ctl_top`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` and `pin_drv_low` are 0 and `vec_sel` is 2'b00, without waiting for a clock edge.
- R2: A sequence starts on the first clock edge at which the block is idle and sees `wdog_req`, `cmon_req` or a low `pin_in`. `pin_drv_low` is then 1 for exactly `DRIVE_CYC` (default 16) cycles.
- R3: Once a sequence starts, `sys_rst_n` falls in the same cycle. It rises exactly two cycles after the block returns to idle. For an internal reset this is `DRIVE_CYC + SAMPLE_DLY + 2` (default 26) cycles after the starting edge.
- R4: The line is judged on the edge `SAMPLE_DLY` (default 8) cycles after `pin_drv_low` falls. If it is high there and only a watchdog request is latched, `vec_sel` becomes 2'b01.
- R5: If it is high there and a clock-monitor request is latched, `vec_sel` becomes 2'b10, even when a watchdog request is latched as well.
- R6: A line held low from outside for 32 cycles is classed as external (`vec_sel` = 2'b00), even when a watchdog request arrives in the same cycle. `sys_rst_n` stays low until the line is released and rises on the third cycle after release.
- R7: `vec_sel` changes only at the judging edge. Requests that arrive during a sequence leave it unchanged until then. The value 2'b11 never appears.
- R8: A short outside pulse on the line that is gone by the judging edge, with no internal request latched, yields `vec_sel` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (E) clock |
| por_n | input | 1 | Power-on reset pulse, active low, asynchronous |
| wdog_req | input | 1 | Watchdog timeout request, synchronous to clk |
| cmon_req | input | 1 | Clock-monitor failure request, synchronous to clk |
| pin_in | input | 1 | Sampled level of the board reset line |
| pin_drv_low | output | 1 | 1 pulls the open-drain reset line low |
| sys_rst_n | output | 1 | Internal reset, active low |
| vec_sel | output | 2 | 00 normal, 01 watchdog, 10 clock monitor |

## Verification
The case that matters most is an outside agent pulling the line low in the same cycle that the watchdog raises its request. One sequence then carries both a latched internal cause and an external hold. The bench raises both on one falling edge and keeps the line low for 32 cycles. The run passes only if the vector comes out as normal, the drive pulse still lasts the full length, and the internal reset is released on the third cycle after the line goes free. A second collision sends a clock-monitor request in the middle of a watchdog-started drive. It is judged by the vector holding its old value until the judging edge and then reading clock monitor.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int VEC_W = 2;
  localparam logic [VEC_W-1:0] VEC_NORMAL = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_DRIVE   = 2'd1,
    ST_WAIT    = 2'd2,
    ST_EXTHOLD = 2'd3
  } seq_state_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n_o = sh_q[STAGES-1];
endmodule

// File: rtl/rst_src_latch.sv
module rst_src_latch #(
  parameter int NSRC  = 2,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_o
);
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] pend_d;
  logic            pend_en;

  always_comb begin
    pend_en = clr_i | (|req_i);
    pend_d  = clr_i ? '0 : (pend_q | req_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  // Highest index wins: code is index + 1, zero when nothing pending.
  always_comb begin
    code_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_q[i]) code_o = CODE_W'(i + 1);
    end
  end

  // R5
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|req_i) && !clr_i) |=> (|pend_q));
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int DRIVE_CYC  = 16,
  parameter int SAMPLE_DLY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             pin_i,
  input  logic [VEC_W-1:0] prio_code_i,
  output logic             drv_o,
  output logic             busy_o,
  output logic             judge_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int MAXC  = (DRIVE_CYC > SAMPLE_DLY) ? DRIVE_CYC : SAMPLE_DLY;
  localparam int CNT_W = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_DLY - 1);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             vec_en;
  logic             judge;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    vec_d  = vec_q;
    vec_en = 1'b0;
    judge  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_DRIVE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      ST_DRIVE: begin
        cnt_en = 1'b1;
        if (cnt_q == DRV_LAST) begin
          st_d  = ST_WAIT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == SMP_LAST) begin
          judge  = 1'b1;
          vec_en = 1'b1;
          cnt_d  = '0;
          if (!pin_i) begin
            vec_d = VEC_NORMAL;
            st_d  = ST_EXTHOLD;
          end else begin
            vec_d = prio_code_i;
            st_d  = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_EXTHOLD: begin
        if (pin_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      vec_q <= VEC_NORMAL;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (vec_en) vec_q <= vec_d;
    end
  end

  assign drv_o   = (st_q == ST_DRIVE);
  assign busy_o  = (st_q != ST_IDLE);
  assign judge_o = judge;
  assign vec_o   = vec_q;

  // R7
  vec_only_at_judge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !judge |=> $stable(vec_q));
  // R7
  vec_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_q != 2'b11);
  // R6
  ext_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (judge && !pin_i) |=> (vec_q == VEC_NORMAL));
  // R5
  cmon_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (judge && pin_i && prio_code_i == 2'b10) |=> (vec_q == 2'b10));
endmodule

// File: rtl/rst_ctl_top.sv
module rst_ctl_top
  import rst_seq_pkg::*;
#(
  parameter int DRIVE_CYC   = 16,
  parameter int SAMPLE_DLY  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wdog_req,
  input  logic       cmon_req,
  input  logic       pin_in,
  output logic       pin_drv_low,
  output logic       sys_rst_n,
  output logic [1:0] vec_sel
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]  req_vec;
  logic [VEC_W-1:0] prio_code;
  logic             busy;
  logic             judge;
  logic             start;
  logic             rst_src_n;

  assign req_vec = {cmon_req, wdog_req};
  assign start   = wdog_req | cmon_req | ~pin_in;

  rst_src_latch #(.NSRC(NSRC), .CODE_W(VEC_W)) src_i (
    .clk    (clk),
    .rst_n  (por_n),
    .req_i  (req_vec),
    .clr_i  (judge),
    .code_o (prio_code)
  );

  rst_seq_fsm #(.DRIVE_CYC(DRIVE_CYC), .SAMPLE_DLY(SAMPLE_DLY)) fsm_i (
    .clk         (clk),
    .rst_n       (por_n),
    .start_i     (start),
    .pin_i       (pin_in),
    .prio_code_i (prio_code),
    .drv_o       (pin_drv_low),
    .busy_o      (busy),
    .judge_o     (judge),
    .vec_o       (vec_sel)
  );

  assign rst_src_n = por_n & pin_in & ~busy;

  rst_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .arst_n  (rst_src_n),
    .rst_n_o (sys_rst_n)
  );

  // R3
  drv_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    pin_drv_low |-> !sys_rst_n);
  // R3
  release_sync_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> ($past(rst_src_n) && $past(rst_src_n, 2)));
  // R1
  por_state_chk: assert property (@(posedge clk)
    !por_n |-> (!sys_rst_n && !pin_drv_low && vec_sel == 2'b00));
endmodule

// File: tb/rst_ctl_top_tb_top.sv
module rst_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       por_n;
  logic       wdog_req;
  logic       cmon_req;
  logic       ext_low;
  logic       pin_in;
  logic       pin_drv_low;
  logic       sys_rst_n;
  logic [1:0] vec_sel;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  assign pin_in = ~(pin_drv_low | ext_low);

  rst_ctl_top dut_i (
    .clk         (clk),
    .por_n       (por_n),
    .wdog_req    (wdog_req),
    .cmon_req    (cmon_req),
    .pin_in      (pin_in),
    .pin_drv_low (pin_drv_low),
    .sys_rst_n   (sys_rst_n),
    .vec_sel     (vec_sel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Internal request sequence: counts drive and reset-low cycles after start edge.
  task automatic run_internal(input bit w, input bit c, input int exp_vec, input string tag);
    int drv_n = 0;
    int low_n = 0;
    @(negedge clk);
    wdog_req = w;
    cmon_req = c;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      wdog_req = 1'b0;
      cmon_req = 1'b0;
      if (pin_drv_low) drv_n++;
      if (!sys_rst_n) low_n++;
    end
    check(drv_n == 16, {tag, " R2 drive length"}, drv_n, 16);
    check(low_n == 26, {tag, " R3 reset length"}, low_n, 26);
    check(vec_sel == 2'(exp_vec), {tag, " vector"}, vec_sel, exp_vec);
  endtask

  task automatic t_por;
    por_n = 1'b0;
    #1;
    check(sys_rst_n == 1'b0, "R1 por rst", sys_rst_n, 0);
    check(pin_drv_low == 1'b0, "R1 por drv", pin_drv_low, 0);
    check(vec_sel == 2'b00, "R1 por vec", vec_sel, 0);
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check(sys_rst_n == 1'b0, "R3 por release 1", sys_rst_n, 0);
    @(negedge clk);
    check(sys_rst_n == 1'b1, "R3 por release 2", sys_rst_n, 1);
  endtask

  task automatic t_wdog;
    run_internal(1'b1, 1'b0, 1, "R4 wdog");
  endtask

  task automatic t_both;
    run_internal(1'b1, 1'b1, 2, "R5 both");
  endtask

  task automatic t_cmon;
    run_internal(1'b0, 1'b1, 2, "R5 cmon");
  endtask

  task automatic t_idle_hold;
    bit same = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (vec_sel != 2'b10 || !sys_rst_n) same = 1'b0;
    end
    check(same, "R7 idle hold", vec_sel, 2);
  endtask

  task automatic t_ext_long;
    int drv_n = 0;
    bit held = 1'b1;
    @(negedge clk);
    ext_low  = 1'b1;
    wdog_req = 1'b1;
    for (int i = 1; i <= 32; i++) begin
      @(negedge clk);
      wdog_req = 1'b0;
      if (pin_drv_low) drv_n++;
      if (sys_rst_n) held = 1'b0;
      if (i == 32) ext_low = 1'b0;
    end
    check(drv_n == 16, "R6 drive length", drv_n, 16);
    check(held, "R6 reset held", 0, 0);
    @(negedge clk);
    check(sys_rst_n == 1'b0, "R6 release 1", sys_rst_n, 0);
    @(negedge clk);
    check(sys_rst_n == 1'b0, "R6 release 2", sys_rst_n, 0);
    @(negedge clk);
    check(sys_rst_n == 1'b1, "R6 release 3", sys_rst_n, 1);
    check(vec_sel == 2'b00, "R6 external vec", vec_sel, 0);
  endtask

  task automatic t_midseq;
    int mid = -1;
    @(negedge clk);
    wdog_req = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      wdog_req = 1'b0;
      cmon_req = (i == 5);
      if (i == 10) mid = vec_sel;
      if (i == 23) check(vec_sel == 2'b00, "R7 before judge", vec_sel, 0);
    end
    check(mid == 0, "R7 mid hold", mid, 0);
    check(vec_sel == 2'b10, "R5 late cmon", vec_sel, 2);
  endtask

  task automatic t_ext_short;
    int drv_n = 0;
    @(negedge clk);
    ext_low = 1'b1;
    #1;
    check(sys_rst_n == 1'b0, "R3 async assert", sys_rst_n, 0);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (i == 3) ext_low = 1'b0;
      if (pin_drv_low) drv_n++;
    end
    check(drv_n == 16, "R8 drive length", drv_n, 16);
    check(vec_sel == 2'b00, "R8 short pulse vec", vec_sel, 0);
    check(sys_rst_n == 1'b1, "R8 released", sys_rst_n, 1);
  endtask

  task automatic t_por_mid;
    @(negedge clk);
    wdog_req = 1'b1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      wdog_req = 1'b0;
    end
    por_n = 1'b0;
    #1;
    check(pin_drv_low == 1'b0, "R1 mid por drv", pin_drv_low, 0);
    check(vec_sel == 2'b00, "R1 mid por vec", vec_sel, 0);
    check(sys_rst_n == 1'b0, "R1 mid por rst", sys_rst_n, 0);
    @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    check(sys_rst_n == 1'b0, "R1 post por 1", sys_rst_n, 0);
    @(negedge clk);
    check(sys_rst_n == 1'b1, "R1 post por 2", sys_rst_n, 1);
    check(pin_drv_low == 1'b0, "R1 post por drv", pin_drv_low, 0);
  endtask

  initial begin
    por_n    = 1'b0;
    wdog_req = 1'b0;
    cmon_req = 1'b0;
    ext_low  = 1'b0;
    t_por();
    t_wdog();
    t_both();
    t_idle_hold();
    t_ext_long();
    t_midseq();
    t_ext_short();
    t_cmon();
    t_por_mid();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule